// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs the external bus cycles of a 16-bit processor whose low sixteen bus lines carry the address first and the data later in the same cycle. An internal requester presents one transfer at a time. A transfer is described by a 20-bit address, a direction, a memory or I/O select, an upper-byte flag, write data, a two-bit segment code and the interrupt-enable flag. The controller then drives the shared lines and the bus strobes through the phases T1, T2, T3, any wait states and T4.

The top four address lines carry the high address bits in T1. From T2 onward they carry status: the segment code in the two lowest bits, the interrupt-enable flag above it, and a zero in the top bit. An address-latch strobe in T1 marks when the address is valid. A READY input that is low when sampled adds whole wait cycles. Read data is captured from the bus as the cycle enters T4, and a one-cycle done pulse is raised in T4.

Top module: `mux_bus_cycle_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. A request raised while a cycle is in progress and withdrawn before idle starts no cycle.
- R2: An accepted request is followed by T1, T2, T3, zero or more wait cycles and T4, one clock each, then idle. `ale` is high in T1 only.
- R3: In T1, `ad_oe` is 1, `ad_out` carries address bits 15:0 and `hi_out` carries address bits 19:16.
- R4: From T2 through T4, `hi_out` is {0, interrupt-enable flag, segment code[1:0]}. Segment code 00 means alternate (ES), 01 stack (SS), 10 code or none (CS), 11 data (DS).
- R5: From T1 through T4, `m_io` is 1 for memory and 0 for I/O, and `dt_r` is 1 for a write and 0 for a read.
- R6: From T1 through T4, `bhe_n` is the inverse of the upper-byte flag. It is high when idle.
- R7: `rd_n` is low from T2 through T4 on reads only, and `wr_n` is low from T2 through T4 on writes only. They are never low together.
- R8: `den` is high from T2 through T4 and low in T1 and idle.
- R9: From T2 through T4, a write drives `ad_oe`=1 with the write data on `ad_out`. A read holds `ad_oe`=0.
- R10: READY is sampled only at the end of T3 and of each wait cycle. Each low sample adds one wait cycle, and a low READY at any other time has no effect.
- R11: On a read, `rd_data` takes `ad_in` on the edge that enters T4 and holds it afterwards. `done` is high for exactly the T4 cycle.
- R12: After reset, and whenever idle: `ale`, `m_io`, `dt_r`, `den`, `ad_oe` and `done` are 0, while `bhe_n`, `rd_n`, `wr_n` and `req_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_upper | input | 1 | Upper data byte lines take part |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment code for status |
| req_ie | input | 1 | Interrupt-enable flag for status |
| req_ready | output | 1 | Controller idle, request can be taken |
| ready | input | 1 | Bus ready, low inserts wait cycles |
| ad_in | input | 16 | Shared low lines as seen from the bus |
| ad_out | output | 16 | Shared low lines, driven value |
| ad_oe | output | 1 | Output enable for the shared low lines |
| hi_out | output | 4 | Lines 19:16, address then status |
| ale | output | 1 | Address-latch strobe |
| m_io | output | 1 | Memory (1) or I/O (0) |
| dt_r | output | 1 | Transmit (1) or receive (0) |
| bhe_n | output | 1 | Upper-byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den | output | 1 | Data transceiver enable |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Cycle-complete pulse in T4 |

## Verification
Random transfers mix reads and writes, memory and I/O, both upper-byte settings, all four segment codes, both flag values and zero to five wait cycles. Comparing every pin in every phase against the expected values separates faults in address and status muxing from faults in strobe timing. Directed cases cover the following:
- a cycle with no wait states and a cycle with a long stretch, which separate correct READY sampling from a wrong count;
- READY held low in T1 and T2, which must add no wait;
- a request raised during a busy cycle, which must be dropped;
- read data that changes after T4, which shows the captured value is held.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int SEG_W  = 2;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_t;

    typedef enum logic [SEG_W-1:0] {
        SEG_ALT   = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              mem;
        logic              upper;
        logic [DATA_W-1:0] wdata;
        seg_t              seg;
        logic              ie;
    } req_t;

    typedef struct packed {
        logic              ale;
        logic              m_io;
        logic              dt_r;
        logic              bhe_n;
        logic              rd_n;
        logic              wr_n;
        logic              den;
        logic              ad_oe;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] ad;
    } pins_t;

    // Status nibble placed on the high lines during the data phase.
    function automatic logic [HI_W-1:0] status_bits(seg_t seg, logic ie);
        logic [HI_W-1:0] s;
        s              = '0;
        s[SEG_W-1:0]   = seg;
        s[SEG_W]       = ie;
        return s;
    endfunction

    function automatic logic in_data_phase(phase_t p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
    endfunction

    function automatic pins_t idle_pins();
        pins_t o;
        o.ale   = 1'b0;
        o.m_io  = 1'b0;
        o.dt_r  = 1'b0;
        o.bhe_n = 1'b1;
        o.rd_n  = 1'b1;
        o.wr_n  = 1'b1;
        o.den   = 1'b0;
        o.ad_oe = 1'b0;
        o.hi    = '0;
        o.ad    = '0;
        return o;
    endfunction

    // Pin levels for a given phase of the cycle carrying request r.
    function automatic pins_t pins_for(phase_t p, req_t r);
        pins_t o;
        o = idle_pins();
        if (p != PH_IDLE) begin
            o.m_io  = r.mem;
            o.dt_r  = r.write;
            o.bhe_n = !r.upper;
        end
        if (p == PH_T1) begin
            o.ale   = 1'b1;
            o.ad_oe = 1'b1;
            o.ad    = r.addr[DATA_W-1:0];
            o.hi    = r.addr[ADDR_W-1:DATA_W];
        end
        if (in_data_phase(p)) begin
            o.hi    = status_bits(r.seg, r.ie);
            o.den   = 1'b1;
            o.rd_n  = r.write;
            o.wr_n  = !r.write;
            o.ad_oe = r.write;
            o.ad    = r.write ? r.wdata : '0;
        end
        return o;
    endfunction

endpackage

// File: rtl/mbc_sequencer.sv
module mbc_sequencer
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  req_t   req_in,
    input  logic   ready,
    output phase_t phase,
    output phase_t phase_nxt,
    output req_t   cur,
    output req_t   cur_nxt,
    output logic   req_ready
);

    logic accept;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign cur_nxt   = accept ? req_in : cur;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: phase_nxt = req_valid ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nxt = PH_T2;
            PH_T2:   phase_nxt = PH_T3;
            PH_T3,
            PH_TW:   phase_nxt = ready ? PH_T4 : PH_TW;
            PH_T4:   phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
        end else begin
            phase <= phase_nxt;
            cur   <= cur_nxt;
        end
    end

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_T3 || phase == PH_TW) && !ready) |=> (phase == PH_TW)); // R10
    AST_READY_ENDS: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_T3 || phase == PH_TW) && ready) |=> (phase == PH_T4)); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(cur)); // R1
    AST_T1_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T1) |-> ($past(phase) == PH_IDLE)); // R2

endmodule

// File: rtl/mbc_pin_drive.sv
module mbc_pin_drive
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_nxt,
    input  req_t   cur_nxt,
    output pins_t  pins
);

    always_ff @(posedge clk) begin
        if (rst) pins <= idle_pins();
        else     pins <= pins_for(phase_nxt, cur_nxt);
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!pins.rd_n && !pins.wr_n)); // R7
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pins.ale |=> !pins.ale); // R2
    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        pins.ale |-> (pins.ad_oe && !pins.den)); // R3
    AST_DEN_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!pins.rd_n || !pins.wr_n) |-> pins.den); // R8

endmodule

// File: rtl/mbc_read_capture.sv
module mbc_read_capture
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase_nxt,
    input  logic              is_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic enter_t4;

    assign enter_t4 = (phase_nxt == PH_T4);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= enter_t4;
            if (enter_t4 && !is_write) rd_data <= ad_in;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(enter_t4) |-> $stable(rd_data)); // R11

endmodule

// File: rtl/mux_bus_cycle_ctrl.sv
module mux_bus_cycle_ctrl
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_upper,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    output logic              req_ready,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              ale,
    output logic              m_io,
    output logic              dt_r,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    req_t   req_in, cur, cur_nxt;
    phase_t phase, phase_nxt;
    pins_t  pins;

    always_comb begin
        req_in.addr  = req_addr;
        req_in.write = req_write;
        req_in.mem   = req_mem;
        req_in.upper = req_upper;
        req_in.wdata = req_wdata;
        req_in.seg   = seg_t'(req_seg);
        req_in.ie    = req_ie;
    end

    mbc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .ready     (ready),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .cur       (cur),
        .cur_nxt   (cur_nxt),
        .req_ready (req_ready)
    );

    mbc_pin_drive u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase_nxt (phase_nxt),
        .cur_nxt   (cur_nxt),
        .pins      (pins)
    );

    mbc_read_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .phase_nxt (phase_nxt),
        .is_write  (cur.write),
        .ad_in     (ad_in),
        .rd_data   (rd_data),
        .done      (done)
    );

    assign ale    = pins.ale;
    assign m_io   = pins.m_io;
    assign dt_r   = pins.dt_r;
    assign bhe_n  = pins.bhe_n;
    assign rd_n   = pins.rd_n;
    assign wr_n   = pins.wr_n;
    assign den    = pins.den;
    assign ad_oe  = pins.ad_oe;
    assign hi_out = pins.hi;
    assign ad_out = pins.ad;

    AST_DONE_IN_T4: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_T4)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (rd_n && wr_n && !den && !ad_oe)); // R12

endmodule

// File: tb/mux_bus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module mux_bus_cycle_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_mem, req_upper, req_ie, ready;
    logic [19:0] req_addr;
    logic [15:0] req_wdata, ad_in;
    logic [1:0]  req_seg;
    logic        req_ready, ad_oe, ale, m_io, dt_r, bhe_n, rd_n, wr_n, den, done;
    logic [15:0] ad_out, rd_data;
    logic [3:0]  hi_out;

    int checks = 0;
    int errors = 0;

    logic [19:0] e_addr;
    logic        e_wr, e_mem, e_up, e_ie;
    logic [15:0] e_wd, e_rd;
    logic [1:0]  e_seg;

    always #2 clk = ~clk;

    mux_bus_cycle_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_mem(req_mem), .req_upper(req_upper),
        .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie),
        .req_ready(req_ready), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .hi_out(hi_out), .ale(ale), .m_io(m_io), .dt_r(dt_r),
        .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .den(den),
        .rd_data(rd_data), .done(done)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_hi(input int ph);
        return (ph == 1) ? e_addr[19:16] : {1'b0, e_ie, e_seg};
    endfunction

    // ph: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait
    task automatic check_phase(input int ph);
        if (ph == 0) begin
            chk("R12 idle pins", {10'b0, ale, m_io, dt_r, bhe_n, rd_n, wr_n, den, ad_oe, done, req_ready},
                {10'b0, 10'b0001110001});
        end else begin
            chk("R2 ale", ale, (ph == 1));
            chk(ph == 1 ? "R3 high address" : "R4 status", hi_out, exp_hi(ph));
            chk("R5 type", {m_io, dt_r}, {e_mem, e_wr});
            chk("R6 bhe_n", bhe_n, !e_up);
            chk("R7 strobes", {rd_n, wr_n}, (ph == 1) ? 2'b11 : {e_wr, !e_wr});
            chk("R8 den", den, (ph != 1));
            if (ph == 1)      chk("R3 address", {ad_oe, ad_out}, {1'b1, e_addr[15:0]});
            else if (e_wr)    chk("R9 write data", {ad_oe, ad_out}, {1'b1, e_wd});
            else              chk("R9 released", ad_oe, 1'b0);
            chk("R11 done", done, (ph == 4));
            chk("R1 busy", req_ready, 1'b0);
            if (ph == 4 && !e_wr) chk("R11 read data", rd_data, e_rd);
        end
    endtask

    task automatic run(input logic [19:0] a, input logic wr, input logic mem, input logic up,
                       input logic [15:0] wd, input logic [1:0] seg, input logic ie,
                       input int waits, input logic glitch, input logic poke);
        @(negedge clk);
        e_addr = a; e_wr = wr; e_mem = mem; e_up = up; e_wd = wd; e_seg = seg; e_ie = ie;
        e_rd = 16'($urandom);
        req_addr = a; req_write = wr; req_mem = mem; req_upper = up;
        req_wdata = wd; req_seg = seg; req_ie = ie; req_valid = 1'b1;
        ad_in = 16'($urandom);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = 20'($urandom); req_wdata = 16'($urandom);
        check_phase(1);
        ready = !glitch;                           // R10: ignored at end of T1
        @(negedge clk);
        check_phase(2);
        ready = !glitch;                           // R10: ignored at end of T2
        if (poke) req_valid = 1'b1;                // R1: request while busy
        @(negedge clk);
        check_phase(3);
        req_valid = 1'b0;
        ad_in = e_rd;
        ready = (waits == 0);
        for (int w = waits; w > 0; w--) begin
            @(negedge clk);
            check_phase(5);
            ready = (w == 1);
        end
        @(negedge clk);
        check_phase(4);
        ad_in = 16'($urandom);
        ready = 1'b1;
        @(negedge clk);
        check_phase(0);
        if (!e_wr) chk("R11 held", rd_data, e_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4817));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_mem = 1'b0;
        req_upper = 1'b0; req_wdata = '0; req_seg = '0; req_ie = 1'b0; ready = 1'b1; ad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_phase(0);                                             // R12 reset state
        chk("R11 reset data", rd_data, 16'h0);

        run(20'hABCDE, 1'b0, 1'b1, 1'b1, 16'h0000, 2'b11, 1'b1, 0, 1'b0, 1'b0);  // R2 no wait read
        run(20'h12345, 1'b1, 1'b0, 1'b0, 16'hBEEF, 2'b00, 1'b0, 5, 1'b0, 1'b0);  // R10 long stretch
        run(20'hF0F0F, 1'b1, 1'b1, 1'b1, 16'h5A5A, 2'b01, 1'b1, 0, 1'b1, 1'b0);  // R10 early low READY
        run(20'h00001, 1'b0, 1'b0, 1'b0, 16'h0000, 2'b10, 1'b0, 1, 1'b0, 1'b1);  // R1 poke while busy
        @(negedge clk);
        chk("R1 ignored request", {ale, req_ready}, 2'b01);

        for (int i = 0; i < 60; i++) begin
            run(20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                2'($urandom), 1'($urandom), int'($urandom % 6), 1'($urandom), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule